// File: doc/BRIEF.md
# Out-of-Order Scheduling Window with Tag Wakeup and Oldest-First Select

This block is the issue queue between rename and execution in an out-of-order core. A renamed instruction arrives with an opcode, a destination tag and two source operands. Each source either carries its value already or names the tag of the producer it is waiting for. The instruction is parked in one of eight slots until both of its sources hold values.

A single result bus carries a producer tag and its value. Every waiting source compares the bus tag with its own. On a match the source marks itself ready and latches the bus value. Each cycle a picker looks at the slots whose two sources are both ready and sends the oldest of them to the functional unit. So dispatch follows the order in which data becomes available, not the order of arrival. A flush empties the window in one cycle.

Top module: `rs_window`

## Requirements
- R1: After synchronous reset the window holds no instruction, `disp_valid` is 0 and `ins_full` is 0.
- R2: `ins_full` is 1 exactly when all 8 slots are occupied. An insert (`ins_valid`=1) is accepted when `ins_full` is 0 and `flush` is 0. An insert offered while `ins_full` is 1 is dropped and never dispatches.
- R3: A waiting source whose tag equals `bc_tag` while `bc_valid` is 1 becomes ready at that clock edge and holds `bc_val` from then on.
- R4: A source that is already ready keeps its value when a broadcast with a matching tag arrives.
- R5: A broadcast in the same cycle as an accepted insert is also compared with the inserted sources, and it wakes them exactly as it would wake a stored source.
- R6: An instruction is offered on the dispatch port only when both sources are ready. `disp_op`, `disp_a`, `disp_b` and `disp_dtag` then carry its opcode, first-source value, second-source value and destination tag. An instruction that is ready at an edge is offered in the cycle after that edge.
- R7: At most one instruction is dispatched per cycle. Among the ready instructions, the one accepted earliest is chosen, even if younger instructions became ready first. A dispatched instruction leaves the window at the next edge.
- R8: `flush` suppresses dispatch in its own cycle, drops an insert offered in that cycle, and leaves the window empty after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the window |
| ins_valid | input | 1 | Insert request |
| ins_op | input | 5 | Opcode of the inserted instruction |
| ins_tag_a | input | 6 | Producer tag of source A |
| ins_rdy_a | input | 1 | Source A value already present |
| ins_val_a | input | 32 | Value of source A when ready |
| ins_tag_b | input | 6 | Producer tag of source B |
| ins_rdy_b | input | 1 | Source B value already present |
| ins_val_b | input | 32 | Value of source B when ready |
| ins_dtag | input | 6 | Destination tag |
| ins_full | output | 1 | All slots occupied, inserts are dropped |
| bc_valid | input | 1 | Result bus carries a result |
| bc_tag | input | 6 | Tag of the broadcast result |
| bc_val | input | 32 | Value of the broadcast result |
| disp_valid | output | 1 | An instruction is dispatched this cycle |
| disp_op | output | 5 | Dispatched opcode |
| disp_a | output | 32 | Dispatched source A value |
| disp_b | output | 32 | Dispatched source B value |
| disp_dtag | output | 6 | Dispatched destination tag |

## Verification
An insert or a broadcast is registered at the edge that samples it, and the dispatch port is decoded from the registered slots without a further register. So an instruction that becomes ready at edge N appears on the dispatch port in the cycle that follows edge N. `ins_full` likewise reflects inserts one edge later. The bench drives inputs on the falling edge and compares outputs just after it. It advances a behavioural model (arrays ordered by arrival number) on each rising edge, so every expected value lines up with the edge that caused it. Directed sequences cover out-of-order wakeup, a broadcast on an already-ready source, a same-cycle insert and broadcast, a full window and a flush. Random traffic follows them.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int RS_DEPTH = 8;
    localparam int TAG_W    = 6;
    localparam int DATA_W   = 32;
    localparam int OP_W     = 5;
    localparam int RANK_W   = $clog2(RS_DEPTH);
    localparam int IDX_W    = $clog2(RS_DEPTH);
    localparam int CNT_W    = $clog2(RS_DEPTH + 1);

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
        logic              rdy;
    } opnd_t;

    typedef struct packed {
        logic              vld;
        logic [OP_W-1:0]   op;
        opnd_t             a;
        opnd_t             b;
        logic [TAG_W-1:0]  dtag;
        logic [RANK_W-1:0] rank;   // number of older occupants
    } slot_t;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } result_t;

    // Wake a waiting operand when the result bus names its producer.
    function automatic opnd_t snoop(opnd_t s, result_t r);
        opnd_t o;
        o = s;
        if (!s.rdy && r.vld && (r.tag == s.tag)) begin
            o.rdy = 1'b1;
            o.val = r.val;
        end
        return o;
    endfunction

    function automatic logic eligible(slot_t e);
        return e.vld & e.a.rdy & e.b.rdy;
    endfunction

endpackage

// File: rtl/rs_alloc.sv
module rs_alloc
    import rs_pkg::*;
(
    input  logic [RS_DEPTH-1:0] vld,
    output logic [RS_DEPTH-1:0] free_oh,
    output logic                full,
    output logic [CNT_W-1:0]    used
);
    always_comb begin
        free_oh = '0;
        for (int i = RS_DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_oh    = '0;
                free_oh[i] = 1'b1;
            end
        end
    end

    always_comb begin
        used = '0;
        for (int i = 0; i < RS_DEPTH; i++) begin
            used = used + CNT_W'(vld[i]);
        end
    end

    assign full = &vld;

endmodule

// File: rtl/rs_select.sv
module rs_select
    import rs_pkg::*;
(
    input  logic [RS_DEPTH-1:0]        elig,
    input  logic [RS_DEPTH*RANK_W-1:0] ranks,
    output logic [RS_DEPTH-1:0]        grant,
    output logic                       any,
    output logic [RANK_W-1:0]          win_rank
);
    logic [IDX_W-1:0]  best;
    logic [RANK_W-1:0] r;

    always_comb begin
        any      = 1'b0;
        best     = '0;
        win_rank = '0;
        r        = '0;
        for (int i = 0; i < RS_DEPTH; i++) begin
            r = ranks[i*RANK_W +: RANK_W];
            if (elig[i] && (!any || (r < win_rank))) begin
                any      = 1'b1;
                best     = IDX_W'(i);
                win_rank = r;
            end
        end
        grant = any ? (RS_DEPTH'(1) << best) : '0;
    end

endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_en,
    input  slot_t             wr_slot,
    input  logic              grant,
    input  logic              fire,
    input  logic [RANK_W-1:0] fire_rank,
    input  result_t           res,
    output slot_t             q
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wr_slot;
        end else if (grant && fire) begin
            q.vld <= 1'b0;
        end else if (q.vld) begin
            q.a <= snoop(q.a, res);
            q.b <= snoop(q.b, res);
            if (fire && (q.rank > fire_rank)) begin
                q.rank <= q.rank - 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_window.sv
module rs_window
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              ins_valid,
    input  logic [OP_W-1:0]   ins_op,
    input  logic [TAG_W-1:0]  ins_tag_a,
    input  logic              ins_rdy_a,
    input  logic [DATA_W-1:0] ins_val_a,
    input  logic [TAG_W-1:0]  ins_tag_b,
    input  logic              ins_rdy_b,
    input  logic [DATA_W-1:0] ins_val_b,
    input  logic [TAG_W-1:0]  ins_dtag,
    output logic              ins_full,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_dtag
);
    result_t                    res;
    slot_t                      slots [RS_DEPTH];
    slot_t                      new_slot;
    logic [RS_DEPTH-1:0]        vld_vec;
    logic [RS_DEPTH-1:0]        elig_vec;
    logic [RS_DEPTH-1:0]        free_oh;
    logic [RS_DEPTH-1:0]        grant_vec;
    logic [RS_DEPTH*RANK_W-1:0] rank_flat;
    logic [CNT_W-1:0]           used;
    logic [CNT_W-1:0]           new_rank;
    logic [RANK_W-1:0]          win_rank;
    logic                       any_rdy;
    logic                       fire;
    logic                       accept;

    assign res    = '{vld: bc_valid, tag: bc_tag, val: bc_val};
    assign fire   = any_rdy & ~flush;
    assign accept = ins_valid & ~ins_full & ~flush;

    rs_alloc u_alloc (
        .vld     (vld_vec),
        .free_oh (free_oh),
        .full    (ins_full),
        .used    (used)
    );

    rs_select u_sel (
        .elig     (elig_vec),
        .ranks    (rank_flat),
        .grant    (grant_vec),
        .any      (any_rdy),
        .win_rank (win_rank)
    );

    // Incoming instruction, already snooped against this cycle's bus.
    assign new_rank = used - CNT_W'(fire);

    always_comb begin
        new_slot.vld  = 1'b1;
        new_slot.op   = ins_op;
        new_slot.a    = snoop('{tag: ins_tag_a, val: ins_val_a, rdy: ins_rdy_a}, res);
        new_slot.b    = snoop('{tag: ins_tag_b, val: ins_val_b, rdy: ins_rdy_b}, res);
        new_slot.dtag = ins_dtag;
        new_slot.rank = new_rank[RANK_W-1:0];
    end

    for (genvar g = 0; g < RS_DEPTH; g++) begin : g_slot
        rs_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush),
            .wr_en     (accept & free_oh[g]),
            .wr_slot   (new_slot),
            .grant     (grant_vec[g]),
            .fire      (fire),
            .fire_rank (win_rank),
            .res       (res),
            .q         (slots[g])
        );
        assign vld_vec[g]                       = slots[g].vld;
        assign elig_vec[g]                      = eligible(slots[g]);
        assign rank_flat[g*RANK_W +: RANK_W]    = slots[g].rank;
    end

    always_comb begin
        disp_op   = '0;
        disp_a    = '0;
        disp_b    = '0;
        disp_dtag = '0;
        for (int i = 0; i < RS_DEPTH; i++) begin
            if (grant_vec[i]) begin
                disp_op   = disp_op   | slots[i].op;
                disp_a    = disp_a    | slots[i].a.val;
                disp_b    = disp_b    | slots[i].b.val;
                disp_dtag = disp_dtag | slots[i].dtag;
            end
        end
    end

    assign disp_valid = fire;

endmodule

// File: rtl/rs_window_chk.sv
module rs_window_chk
    import rs_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                flush,
    input logic                ins_valid,
    input logic                ins_full,
    input logic                disp_valid,
    input logic [RS_DEPTH-1:0] vld_vec,
    input logic [RS_DEPTH-1:0] grant_vec,
    input logic [RS_DEPTH-1:0] elig_vec
);
    logic armed = 1'b0;
    logic acc;

    always_ff @(posedge clk) armed <= !rst;

    assign acc = ins_valid & ~ins_full & ~flush;

    // R2
    occupancy_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(flush) |-> ($countones(vld_vec) ==
            $countones($past(vld_vec)) + int'($past(acc)) - int'($past(disp_valid))));

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        flush |=> (vld_vec == '0));

    // R8
    flush_no_disp_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        flush |-> !disp_valid);

    // R7
    single_grant_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $onehot0(grant_vec));

    // R6
    grant_ready_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ((grant_vec & ~elig_vec) == '0));

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        $past(rst) |-> (vld_vec == '0));

endmodule

bind rs_window rs_window_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .ins_valid  (ins_valid),
    .ins_full   (ins_full),
    .disp_valid (disp_valid),
    .vld_vec    (vld_vec),
    .grant_vec  (grant_vec),
    .elig_vec   (elig_vec)
);

// File: tb/sim_rs_window.sv
`timescale 1ns/1ps
module sim_rs_window;
    import rs_pkg::*;

    logic clk = 1'b0;
    logic rst, flush, ins_valid, ins_rdy_a, ins_rdy_b, bc_valid;
    logic [OP_W-1:0]   ins_op;
    logic [TAG_W-1:0]  ins_tag_a, ins_tag_b, ins_dtag, bc_tag;
    logic [DATA_W-1:0] ins_val_a, ins_val_b, bc_val;
    logic ins_full, disp_valid;
    logic [OP_W-1:0]   disp_op;
    logic [DATA_W-1:0] disp_a, disp_b;
    logic [TAG_W-1:0]  disp_dtag;

    always #2.5 clk = ~clk;

    rs_window u0 (.*);

    // Behavioural model: slots ordered by arrival number.
    bit                m_v  [RS_DEPTH];
    int                m_sq [RS_DEPTH];
    logic [OP_W-1:0]   m_op [RS_DEPTH];
    logic [TAG_W-1:0]  m_ta [RS_DEPTH], m_tb [RS_DEPTH], m_dt [RS_DEPTH];
    logic [DATA_W-1:0] m_va [RS_DEPTH], m_vb [RS_DEPTH];
    bit                m_ra [RS_DEPTH], m_rb [RS_DEPTH];
    int seq_ctr = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < RS_DEPTH; i++) if (m_v[i]) c++;
        return c;
    endfunction

    function automatic int m_pick();
        int w = -1;
        for (int i = 0; i < RS_DEPTH; i++)
            if (m_v[i] && m_ra[i] && m_rb[i] && (w < 0 || m_sq[i] < m_sq[w])) w = i;
        return w;
    endfunction

    task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int w;
        int c;
        w = flush ? -1 : m_pick();
        c = m_count();
        if (flush) begin
            for (int i = 0; i < RS_DEPTH; i++) m_v[i] = 1'b0;
            return;
        end
        if (w >= 0) m_v[w] = 1'b0;
        for (int i = 0; i < RS_DEPTH; i++) begin
            if (m_v[i] && bc_valid) begin
                if (!m_ra[i] && m_ta[i] == bc_tag) begin m_ra[i] = 1'b1; m_va[i] = bc_val; end
                if (!m_rb[i] && m_tb[i] == bc_tag) begin m_rb[i] = 1'b1; m_vb[i] = bc_val; end
            end
        end
        if (ins_valid && c < RS_DEPTH) begin
            for (int i = 0; i < RS_DEPTH; i++) begin
                if (!m_v[i] && i != w) begin
                    m_v[i] = 1'b1; m_sq[i] = seq_ctr++; m_op[i] = ins_op;
                    m_ta[i] = ins_tag_a; m_ra[i] = ins_rdy_a; m_va[i] = ins_val_a;
                    m_tb[i] = ins_tag_b; m_rb[i] = ins_rdy_b; m_vb[i] = ins_val_b;
                    m_dt[i] = ins_dtag;
                    if (bc_valid && !m_ra[i] && m_ta[i] == bc_tag) begin m_ra[i] = 1'b1; m_va[i] = bc_val; end
                    if (bc_valid && !m_rb[i] && m_tb[i] == bc_tag) begin m_rb[i] = 1'b1; m_vb[i] = bc_val; end
                    break;
                end
            end
        end
    endtask

    task automatic tick();
        int w;
        bit ef;
        #1;
        w  = flush ? -1 : m_pick();
        ef = (m_count() == RS_DEPTH);
        chk(ins_full == ef, "R2 ins_full", 64'(ins_full), 64'(ef));
        chk(disp_valid == (w >= 0), "disp_valid", 64'(disp_valid), 64'(w >= 0));
        if (w >= 0 && disp_valid) begin
            chk(disp_op == m_op[w],   "R6 disp_op",   64'(disp_op),   64'(m_op[w]));
            chk(disp_a == m_va[w],    "R6 disp_a",    64'(disp_a),    64'(m_va[w]));
            chk(disp_b == m_vb[w],    "R6 disp_b",    64'(disp_b),    64'(m_vb[w]));
            chk(disp_dtag == m_dt[w], "R6 disp_dtag", 64'(disp_dtag), 64'(m_dt[w]));
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        ins_valid = 1'b0; bc_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic put(input logic [OP_W-1:0] op, input logic [TAG_W-1:0] ta, input bit ra,
                       input logic [DATA_W-1:0] va, input logic [TAG_W-1:0] tb, input bit rb,
                       input logic [DATA_W-1:0] vb, input logic [TAG_W-1:0] dt);
        ins_valid = 1'b1; ins_op = op;
        ins_tag_a = ta; ins_rdy_a = ra; ins_val_a = va;
        ins_tag_b = tb; ins_rdy_b = rb; ins_val_b = vb; ins_dtag = dt;
    endtask

    task automatic bcast(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v);
        bc_valid = 1'b1; bc_tag = t; bc_val = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        idle();
        put(0, 0, 0, 0, 0, 0, 0, 0); ins_valid = 1'b0;
        bcast(0, 0); bc_valid = 1'b0;
        for (int i = 0; i < RS_DEPTH; i++) m_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        cur_req = "R1";
        tick(); tick();

        // R6: fully ready instruction dispatches the cycle after insert
        cur_req = "R6";
        put(5'd3, 6'd1, 1, 32'h11, 6'd2, 1, 32'h22, 6'd40); tick();
        idle(); tick(); tick();

        // R3 / R7: younger wakes first and leaves first; older follows
        cur_req = "R3";
        put(5'd4, 6'd10, 0, 0, 6'd1, 1, 32'hA1, 6'd41); tick();
        put(5'd5, 6'd11, 0, 0, 6'd1, 1, 32'hB1, 6'd42); tick();
        idle(); bcast(6'd11, 32'hBEEF); tick();
        cur_req = "R7";
        idle(); bcast(6'd10, 32'hCAFE); tick();
        idle(); tick(); tick();

        // R4: ready source keeps its value under a matching broadcast
        cur_req = "R4";
        put(5'd6, 6'd10, 1, 32'h1234, 6'd12, 0, 0, 6'd43); tick();
        idle(); bcast(6'd10, 32'hDEAD); tick();
        idle(); bcast(6'd12, 32'h5678); tick();
        idle(); tick(); tick();

        // R5: broadcast in the insert cycle wakes the new instruction
        cur_req = "R5";
        put(5'd7, 6'd20, 0, 0, 6'd20, 0, 0, 6'd44); bcast(6'd20, 32'h77); tick();
        idle(); tick(); tick();

        // R2: fill the window, then an insert while full is dropped
        cur_req = "R2";
        for (int k = 0; k < RS_DEPTH; k++) begin
            put(5'(k), 6'd30, 0, 0, 6'd31, 1, 32'(k), 6'(k)); tick();
        end
        put(5'd31, 6'd30, 0, 0, 6'd31, 1, 32'h999, 6'd63); tick();
        idle(); bcast(6'd30, 32'h3030); tick();
        cur_req = "R7";
        idle();
        for (int k = 0; k < RS_DEPTH + 2; k++) tick();

        // R8: flush with concurrent insert and broadcast
        cur_req = "R8";
        put(5'd8, 6'd33, 0, 0, 6'd34, 0, 0, 6'd45); tick();
        put(5'd9, 6'd1, 1, 32'h5, 6'd1, 1, 32'h6, 6'd46); tick();
        put(5'd10, 6'd1, 1, 32'h7, 6'd1, 1, 32'h8, 6'd47); flush = 1'b1; bcast(6'd33, 32'h1); tick();
        idle(); bcast(6'd34, 32'h2); tick();
        idle(); bcast(6'd33, 32'h3); tick();
        idle(); tick();

        // R7: random traffic
        cur_req = "R7";
        for (int k = 0; k < 4000; k++) begin
            idle();
            if ($urandom_range(1, 0) == 1)
                put(5'($urandom), 6'($urandom_range(7, 0)), bit'($urandom_range(1, 0)), $urandom,
                    6'($urandom_range(7, 0)), bit'($urandom_range(1, 0)), $urandom, 6'($urandom));
            if ($urandom_range(9, 0) < 4) bcast(6'($urandom_range(7, 0)), $urandom);
            if ($urandom_range(99, 0) == 0) flush = 1'b1;
            tick();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule